// File: doc/BRIEF.md
# Translation Miss Dispatcher

This block sits after the lookup stage of a second-level translation cache. It takes the final lookup verdict for one translation request and steers that request to exactly one of six destinations. The destinations are the response path back to the first-level TLB, the last-level walker, the full page walker, the guest-stage walker, the guest-stage response arbiter and the miss queue. The decision is made from the hit depth, the request kind, the origin of the request, the bypass flag and the readiness of the two walkers. An ECC error and a bypassed lookup both count as a miss.

Several conditions are evaluated in parallel, and they are mutually exclusive. Walker readiness changes the route rather than stalling the block: a request that a walker cannot take goes to the miss queue instead. The block is purely combinational. The request is accepted in the same cycle that its destination handshakes.

Back-pressure rules:
- `in_ready` equals the `dst_ready` bit of the one destination whose `dst_valid` is raised.
- The block holds the request while that bit is low, and the upstream stage must keep its inputs stable until `in_ready` is high.
- In practice only the guest-stage walker and the fixed-path sinks (TLB response, guest response arbiter, miss queue) ever hold a request. Both walker-ready bits feed the routing choice, so a route to the last-level walker or the full walker is only chosen when that walker's ready bit is already high.
- A dropped prefetch is always accepted.

Top module: `xlat_miss_dispatch`

## Requirements
- R1: Destination index map: 0 = TLB response, 1 = last-level walker, 2 = full walker, 3 = guest-stage walker, 4 = guest response arbiter, 5 = miss queue. With `in_valid` high, exactly one `dst_valid` bit is high unless the request is dropped. With `in_valid` low, none is high.
- R2: For a request of kind normal (0) or prefetch (1), an effective leaf hit on stage type host (0), first-stage-only (1) or second-stage-only (2) goes to the TLB response (index 0).
- R3: A "walker case" is either a two-stage (3) leaf hit or a deep miss (see R8). A non-bypassed walker case goes to the full walker (index 2) when the request came from the miss queue (`in_from_mq`=1) and `ptw_ready` is high.
- R4: A leaf miss with a second-level hit, on a stage type other than 2, that is not bypassed goes to the last-level walker (index 1) when `llptw_ready` is high.
- R5: A walker case that came from the first-level TLB (`in_from_mq`=0), or that meets a low `ptw_ready`, goes to the miss queue (index 5).
- R6: A second-level hit whose last-level walker is not ready goes to the miss queue.
- R7: A bypassed request has its hit flags ignored. A normal bypassed request goes to the miss queue and never to a walker.
- R8: A deep miss is a leaf miss together with either a second-level miss or stage type 2; for stage type 2 the second-level hit is ignored.
- R9: A guest-walk request (kind 2) goes to the guest response arbiter (index 4) on a leaf hit and to the guest-stage walker (index 3) otherwise. `gw_nofill` equals the bypass flag whenever index 3 is valid.
- R10: While the guest-stage walker is chosen and `dst_ready[3]` is low, `in_ready` is low.
- R11: `in_ecc_err` turns both hit flags into misses.
- R12: A prefetch whose route would be the miss queue is dropped. No `dst_valid` is raised, `in_ready` is high and `drop_pulse` is high.
- R13: `in_ready` equals the ready bit of the selected destination. `dst_id` always carries `in_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle |
| in_id | input | ID_W | Request tag, passed to every destination |
| in_kind | input | 2 | 0 normal, 1 prefetch, 2 guest walk |
| in_stage | input | 2 | 0 host, 1 first-stage-only, 2 second-stage-only, 3 two-stage |
| in_from_mq | input | 1 | 1 when the request came from the miss queue, 0 when it came from the first-level TLB |
| in_bypass | input | 1 | Lookup collided with a refill in flight |
| in_leaf_hit | input | 1 | Leaf-level hit |
| in_l2_hit | input | 1 | Second-level (non-leaf) hit |
| in_ecc_err | input | 1 | ECC failure on the lookup |
| llptw_ready | input | 1 | Last-level walker can accept |
| ptw_ready | input | 1 | Full walker is idle and can accept |
| dst_valid | output | 6 | One valid bit per destination, indexed as in R1 |
| dst_ready | input | 6 | One ready bit per destination |
| dst_id | output | ID_W | Request tag toward the destinations |
| gw_nofill | output | 1 | Guest walker must not refill the cache |
| drop_pulse | output | 1 | Prefetch discarded this cycle |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and `dst_valid`, `in_ready`, `gw_nofill` and `drop_pulse`. Each scenario task applies its inputs just after a falling clock edge and samples all outputs 1 ns later, well before the next rising edge. This keeps every comparison clear of the edge, and no check waits a cycle for a result that has no latency. The back-pressure cases R10 and R13 are checked by lowering a single ready bit and observing `in_ready` within that same window.

// File: rtl/xlat_dispatch_pkg.sv
package xlat_dispatch_pkg;
  localparam int unsigned NUM_DEST = 6;

  localparam int unsigned D_TLB   = 0;
  localparam int unsigned D_LLW   = 1;
  localparam int unsigned D_FULLW = 2;
  localparam int unsigned D_GWALK = 3;
  localparam int unsigned D_GRESP = 4;
  localparam int unsigned D_MQ    = 5;

  typedef enum logic [1:0] {
    K_NORMAL   = 2'd0,
    K_PREFETCH = 2'd1,
    K_GWALK    = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_HOST  = 2'd0,
    ST_S1    = 2'd1,
    ST_S2    = 2'd2,
    ST_TWO   = 2'd3
  } stage_e;
endpackage

// File: rtl/xlat_dispatch_route.sv
module xlat_dispatch_route
  import xlat_dispatch_pkg::*;
(
  input  logic                req_valid,
  input  logic [1:0]          kind,
  input  logic [1:0]          stage,
  input  logic                from_mq,
  input  logic                bypass,
  input  logic                leaf_hit,
  input  logic                l2_hit,
  input  logic                ecc_err,
  input  logic                llptw_ready,
  input  logic                ptw_ready,
  output logic [NUM_DEST-1:0] sel,
  output logic                drop
);
  logic hits_ok, eff_leaf, eff_l2;
  logic is_gw, is_pf;
  logic deep_miss, s1_leaf, walker_case, l2_case;
  logic to_llw, to_fullw, to_mq_want;

  always_comb begin
    // R7 R11: bypass or ECC failure turns the lookup into a miss
    hits_ok   = !ecc_err && !bypass;
    eff_leaf  = leaf_hit && hits_ok;
    eff_l2    = l2_hit && hits_ok;
    is_gw     = (kind == K_GWALK);
    is_pf     = (kind == K_PREFETCH);
    // R8: second-stage-only ignores the second-level hit
    deep_miss = !eff_leaf && ((stage == ST_S2) || !eff_l2);
    s1_leaf   = eff_leaf && (stage == ST_TWO);
    walker_case = deep_miss || s1_leaf;
    l2_case   = !eff_leaf && eff_l2 && (stage != ST_S2);

    to_llw     = l2_case && !bypass && llptw_ready;
    to_fullw   = walker_case && !bypass && from_mq && ptw_ready;
    to_mq_want = bypass
              || (walker_case && (!from_mq || !ptw_ready))
              || (l2_case && !llptw_ready);

    sel  = '0;
    drop = 1'b0;
    if (req_valid) begin
      if (is_gw) begin
        sel[D_GRESP] = eff_leaf;
        sel[D_GWALK] = !eff_leaf;
      end else begin
        sel[D_TLB]   = eff_leaf && !s1_leaf;
        sel[D_LLW]   = to_llw;
        sel[D_FULLW] = to_fullw;
        sel[D_MQ]    = to_mq_want && !is_pf;
        drop         = to_mq_want && is_pf;
      end
    end
  end

  always_comb begin
    if (req_valid) begin
      // R1
      route_onehot_chk: assert ($countones({sel, drop}) == 1)
        else $error("route selects %0d targets", $countones({sel, drop}));
      // R7
      bypass_no_walker_chk: assert (!(bypass && !is_gw) || (sel[D_LLW] == 1'b0 && sel[D_FULLW] == 1'b0))
        else $error("bypassed request sent to a walker");
      // R12
      drop_prefetch_only_chk: assert (!drop || is_pf)
        else $error("non-prefetch request dropped");
    end else begin
      // R1
      idle_no_route_chk: assert (sel == '0 && !drop)
        else $error("route active without request");
    end
  end
endmodule

// File: rtl/xlat_dispatch_fanout.sv
module xlat_dispatch_fanout
  import xlat_dispatch_pkg::*;
(
  input  logic                req_valid,
  input  logic [NUM_DEST-1:0] sel,
  input  logic                drop,
  input  logic [NUM_DEST-1:0] dst_ready,
  output logic [NUM_DEST-1:0] dst_valid,
  output logic                req_ready
);
  logic [NUM_DEST-1:0] took;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_port
    assign dst_valid[g] = req_valid && sel[g];
    assign took[g]      = sel[g] && dst_ready[g];
  end

  // R13: the chosen sink's ready decides acceptance
  assign req_ready = (|took) || drop;

  always_comb begin
    // R10
    gwalk_stall_chk: assert (!(dst_valid[D_GWALK] && !dst_ready[D_GWALK]) || !req_ready)
      else $error("accepted while guest walker busy");
    // R1
    fanout_onehot_chk: assert ($onehot0(dst_valid))
      else $error("several destinations valid");
  end
endmodule

// File: rtl/xlat_miss_dispatch.sv
module xlat_miss_dispatch
  import xlat_dispatch_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ID_W-1:0]     in_id,
  input  logic [1:0]          in_kind,
  input  logic [1:0]          in_stage,
  input  logic                in_from_mq,
  input  logic                in_bypass,
  input  logic                in_leaf_hit,
  input  logic                in_l2_hit,
  input  logic                in_ecc_err,
  input  logic                llptw_ready,
  input  logic                ptw_ready,
  output logic [NUM_DEST-1:0] dst_valid,
  input  logic [NUM_DEST-1:0] dst_ready,
  output logic [ID_W-1:0]     dst_id,
  output logic                gw_nofill,
  output logic                drop_pulse
);
  logic [NUM_DEST-1:0] sel;
  logic                drop;

  xlat_dispatch_route u_route (
    .req_valid   (in_valid),
    .kind        (in_kind),
    .stage       (in_stage),
    .from_mq     (in_from_mq),
    .bypass      (in_bypass),
    .leaf_hit    (in_leaf_hit),
    .l2_hit      (in_l2_hit),
    .ecc_err     (in_ecc_err),
    .llptw_ready (llptw_ready),
    .ptw_ready   (ptw_ready),
    .sel         (sel),
    .drop        (drop)
  );

  xlat_dispatch_fanout u_fanout (
    .req_valid (in_valid),
    .sel       (sel),
    .drop      (drop),
    .dst_ready (dst_ready),
    .dst_valid (dst_valid),
    .req_ready (in_ready)
  );

  assign dst_id     = in_id;
  // R9: a bypassed guest walk must not refill
  assign gw_nofill  = dst_valid[D_GWALK] && in_bypass;
  assign drop_pulse = drop;

  always_comb begin
    // R7
    if (in_valid && in_bypass && in_kind == K_NORMAL) begin
      bypass_to_mq_chk: assert (dst_valid[D_MQ])
        else $error("bypassed request not queued");
    end
  end
endmodule

// File: tb/xlat_miss_dispatch_bench.sv
module xlat_miss_dispatch_bench;
  localparam int ID_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            in_valid, in_ready, in_from_mq, in_bypass;
  logic            in_leaf_hit, in_l2_hit, in_ecc_err;
  logic            llptw_ready, ptw_ready, gw_nofill, drop_pulse;
  logic [ID_W-1:0] in_id, dst_id;
  logic [1:0]      in_kind, in_stage;
  logic [5:0]      dst_valid, dst_ready;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  xlat_miss_dispatch #(.ID_W(ID_W)) u_xlat_miss_dispatch (
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_kind(in_kind), .in_stage(in_stage), .in_from_mq(in_from_mq),
    .in_bypass(in_bypass), .in_leaf_hit(in_leaf_hit), .in_l2_hit(in_l2_hit),
    .in_ecc_err(in_ecc_err), .llptw_ready(llptw_ready), .ptw_ready(ptw_ready),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_id(dst_id),
    .gw_nofill(gw_nofill), .drop_pulse(drop_pulse)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // kind, stage, from_mq, bypass, leaf, l2, ecc, llptw_rdy, ptw_rdy, dst_ready
  task automatic apply(input logic [1:0] k, input logic [1:0] s, input logic mq,
                       input logic bp, input logic lf, input logic l2, input logic ecc,
                       input logic llr, input logic pr, input logic [5:0] dr);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_stage = s; in_from_mq = mq;
    in_bypass = bp; in_leaf_hit = lf; in_l2_hit = l2; in_ecc_err = ecc;
    llptw_ready = llr; ptw_ready = pr; dst_ready = dr;
    in_id = in_id + 4'd1;
    #1;
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; #1;
    chk("R1 idle valid", dst_valid, 0);
    chk("R1 idle drop", drop_pulse, 0);
  endtask

  task automatic t_leaf();
    apply(2'd0, 2'd0, 1'b0, 0, 1, 1, 0, 1, 1, 6'h3F);
    chk("R2 host leaf", dst_valid, 6'b000001);
    chk("R13 ready", in_ready, 1);
    chk("R13 id", dst_id, in_id);
    apply(2'd0, 2'd1, 1'b1, 0, 1, 0, 0, 1, 1, 6'h3E);
    chk("R2 s1 leaf", dst_valid, 6'b000001);
    chk("R13 tlb busy", in_ready, 0);
  endtask

  task automatic t_two_stage();
    apply(2'd0, 2'd3, 1'b1, 0, 1, 0, 0, 1, 1, 6'h3F);
    chk("R3 two-stage to full walker", dst_valid, 6'b000100);
    apply(2'd0, 2'd3, 1'b0, 0, 1, 0, 0, 1, 1, 6'h3F);
    chk("R5 two-stage from tlb", dst_valid, 6'b100000);
  endtask

  task automatic t_l2();
    apply(2'd0, 2'd0, 1'b0, 0, 0, 1, 0, 1, 0, 6'h3F);
    chk("R4 l2 hit", dst_valid, 6'b000010);
    apply(2'd0, 2'd1, 1'b1, 0, 0, 1, 0, 0, 1, 6'h3F);
    chk("R6 llw busy", dst_valid, 6'b100000);
  endtask

  task automatic t_deep();
    apply(2'd0, 2'd0, 1'b1, 0, 0, 0, 0, 1, 1, 6'h3F);
    chk("R3 deep miss", dst_valid, 6'b000100);
    apply(2'd0, 2'd0, 1'b1, 0, 0, 0, 0, 1, 0, 6'h1F);
    chk("R5 full walker busy", dst_valid, 6'b100000);
    chk("R13 mq busy", in_ready, 0);
    apply(2'd0, 2'd2, 1'b1, 0, 0, 1, 0, 1, 1, 6'h3F);
    chk("R8 s2 ignores l2", dst_valid, 6'b000100);
  endtask

  task automatic t_bypass();
    apply(2'd0, 2'd0, 1'b1, 1, 0, 1, 0, 1, 1, 6'h3F);
    chk("R7 bypass l2", dst_valid, 6'b100000);
    apply(2'd0, 2'd0, 1'b1, 1, 1, 0, 0, 1, 1, 6'h3F);
    chk("R7 bypass leaf ignored", dst_valid, 6'b100000);
  endtask

  task automatic t_guest();
    apply(2'd2, 2'd2, 1'b0, 0, 1, 0, 0, 1, 1, 6'h3F);
    chk("R9 guest hit", dst_valid, 6'b010000);
    apply(2'd2, 2'd2, 1'b0, 0, 0, 0, 0, 1, 1, 6'h3F);
    chk("R9 guest miss", dst_valid, 6'b001000);
    chk("R9 nofill low", gw_nofill, 0);
    apply(2'd2, 2'd2, 1'b0, 1, 1, 0, 0, 1, 1, 6'h3F);
    chk("R9 guest bypass", dst_valid, 6'b001000);
    chk("R9 nofill high", gw_nofill, 1);
    apply(2'd2, 2'd2, 1'b0, 0, 0, 0, 0, 1, 1, 6'h37);
    chk("R10 guest walker stall", in_ready, 0);
    chk("R10 still valid", dst_valid, 6'b001000);
  endtask

  task automatic t_ecc();
    apply(2'd0, 2'd0, 1'b0, 0, 1, 1, 1, 1, 1, 6'h3F);
    chk("R11 ecc miss", dst_valid, 6'b100000);
    apply(2'd0, 2'd0, 1'b1, 0, 1, 0, 1, 1, 1, 6'h3F);
    chk("R11 ecc deep", dst_valid, 6'b000100);
  endtask

  task automatic t_prefetch();
    apply(2'd1, 2'd0, 1'b0, 0, 0, 0, 0, 1, 1, 6'h00);
    chk("R12 drop valid", dst_valid, 0);
    chk("R12 drop ready", in_ready, 1);
    chk("R12 drop pulse", drop_pulse, 1);
    apply(2'd1, 2'd0, 1'b0, 0, 0, 1, 0, 1, 1, 6'h3F);
    chk("R12 prefetch to llw", dst_valid, 6'b000010);
    chk("R12 no drop", drop_pulse, 0);
  endtask

  initial begin
    in_valid = 0; in_id = '0; in_kind = 0; in_stage = 0; in_from_mq = 0;
    in_bypass = 0; in_leaf_hit = 0; in_l2_hit = 0; in_ecc_err = 0;
    llptw_ready = 0; ptw_ready = 0; dst_ready = '0;
    t_idle();
    t_leaf();
    t_two_stage();
    t_l2();
    t_deep();
    t_bypass();
    t_guest();
    t_ecc();
    t_prefetch();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule